// File: doc/BRIEF.md
# Single-Cycle 64-bit Load/Store Core

This block is a small 64-bit processor that completes every instruction in one clock period. The instructions it supports are register add, subtract, AND and OR, a doubleword load, a doubleword store and a branch taken when two registers are equal. The program counter, a 32-entry by 64-bit register file, the immediate extractor, the ALU, the branch-target adder, the decoder and the instruction and data arrays all sit inside the block. The program counter, the register file and the data array change state only on the rising clock edge. Everything else is combinational from the current program counter.

While reset is held low, the instruction and data arrays are filled through a word-wide programming port. After reset is released the core runs on its own. Observation ports show what happens in each cycle: the current program counter, the register write (enable, index, value), the data-memory write (enable, address, value) and whether a branch was taken.

Decoding happens in two levels. The opcode gives a coarse 2-bit ALU class. For register-register instructions that class is then refined by the function fields into the final 4-bit ALU operation code.

Top module: `sc_core64`

## Requirements
- R1: While `rst_n` is low, `pc_o` is 0 after the next rising edge, and `rf_we_o` and `dm_we_o` stay low.
- R2: An instruction that does not take a branch leaves the program counter at its old value plus 4 after the next rising edge.
- R3: Opcode 0110011 is a register instruction that writes `rd` (bits 11:7) with the result of `rs1` (bits 19:15) and `rs2` (bits 24:20). The operations are:
  - add: funct3 (bits 14:12) 000 with funct7 (bits 31:25) 0000000
  - subtract: funct3 000 with funct7 0100000
  - AND: funct3 111
  - OR: funct3 110
- R4: Opcode 0000011 (funct3 011) loads the 64-bit word at `rs1` + sign-extended bits 31:20 into `rd`. The word index in the data array is address bits 8:3.
- R5: Opcode 0100011 (funct3 011) writes `rs2` to `rs1` + sign-extended {bits 31:25, bits 11:7}. It makes no register write.
- R6: Opcode 1100011 (funct3 000) moves the program counter to PC + (sign-extended {bit 31, bit 7, bits 30:25, bits 11:8} shifted left by 1) when `rs1` equals `rs2`, and to PC + 4 otherwise. It makes no register or memory write.
- R7: Register 0 always reads as zero. A write aimed at it has no effect.
- R8: Any other opcode makes no register write, no memory write and no branch. The program counter advances by 4.
- R9: A value stored by one instruction is returned by a load of the same address in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_we | input | 1 | Write one word into an array through the programming port |
| prog_dsel | input | 1 | Target of the programming write: 0 selects the instruction array, 1 selects the data array |
| prog_addr | input | MEM_AW | Word index for the programming write |
| prog_data | input | XLEN | Programming data; the instruction array takes the low 32 bits |
| pc_o | output | XLEN | Current program counter |
| rf_we_o | output | 1 | Register write happening this cycle |
| rf_waddr_o | output | 5 | Destination register index |
| rf_wdata_o | output | XLEN | Register write value |
| dm_we_o | output | 1 | Data-memory write happening this cycle |
| dm_addr_o | output | XLEN | Byte address computed by the ALU |
| dm_wdata_o | output | XLEN | Data-memory write value |
| branch_taken_o | output | 1 | Next program counter is the branch target |

## Verification
Every observation output belongs to the instruction at the current program counter. Each output is valid combinationally within the same cycle, and the effects of that instruction on state are visible one cycle later. The bench therefore releases reset at a falling edge and compares the first expected item a nanosecond later. After that it compares one queued item per cycle at each falling edge, so the program-counter sequence itself checks both the sequential and the branch behaviour. Loads that follow a store, and register reads that follow a write, show whether updates landed on exactly the next rising edge.

// File: rtl/sc_pkg.sv
// Package: shared encodings and the decoded control bundle for the
// single-cycle core. Assumes the fixed 32-bit instruction layout.
package sc_pkg;

    localparam logic [6:0] OPC_REG    = 7'b0110011;
    localparam logic [6:0] OPC_LOAD   = 7'b0000011;
    localparam logic [6:0] OPC_STORE  = 7'b0100011;
    localparam logic [6:0] OPC_BRANCH = 7'b1100011;

    localparam logic [6:0] F7_PLAIN = 7'b0000000;
    localparam logic [6:0] F7_ALT   = 7'b0100000;

    // Coarse ALU class from the opcode
    typedef enum logic [1:0] {
        ACLS_ADD   = 2'b00,
        ACLS_SUB   = 2'b01,
        ACLS_FIELD = 2'b10
    } alu_class_e;

    // Final ALU operation code
    typedef enum logic [3:0] {
        AOP_AND = 4'b0000,
        AOP_OR  = 4'b0001,
        AOP_ADD = 4'b0010,
        AOP_SUB = 4'b0110
    } alu_op_e;

    typedef struct packed {
        logic       b_from_imm;
        logic       wb_from_mem;
        logic       reg_wr;
        logic       mem_rd;
        logic       mem_wr;
        logic       is_branch;
        alu_class_e alu_class;
    } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
// Module: two-level decoder. The first level maps the opcode to datapath
// controls and a coarse ALU class; the second refines that class with
// funct3/funct7 into the ALU operation. Unknown opcodes give a no-op.
module sc_decode
    import sc_pkg::*;
(
    input  logic [6:0] opcode,
    input  logic [2:0] funct3,
    input  logic [6:0] funct7,
    output ctrl_t      ctrl,
    output alu_op_e    alu_op
);

    // Main control: opcode to steering signals
    always_comb begin
        ctrl = '{b_from_imm: 1'b0, wb_from_mem: 1'b0, reg_wr: 1'b0, mem_rd: 1'b0,
                 mem_wr: 1'b0, is_branch: 1'b0, alu_class: ACLS_ADD};
        unique case (opcode)
            OPC_REG: begin
                ctrl.reg_wr    = 1'b1;
                ctrl.alu_class = ACLS_FIELD;
            end
            OPC_LOAD: begin
                ctrl.b_from_imm  = 1'b1;
                ctrl.wb_from_mem = 1'b1;
                ctrl.reg_wr      = 1'b1;
                ctrl.mem_rd      = 1'b1;
            end
            OPC_STORE: begin
                ctrl.b_from_imm = 1'b1;
                ctrl.mem_wr     = 1'b1;
            end
            OPC_BRANCH: begin
                ctrl.is_branch = 1'b1;
                ctrl.alu_class = ACLS_SUB;
            end
            default: ;
        endcase
    end

    // ALU control: class plus function fields to operation code
    always_comb begin
        alu_op = AOP_ADD;
        case (ctrl.alu_class)
            ACLS_SUB:   alu_op = AOP_SUB;
            ACLS_FIELD: begin
                case (funct3)
                    3'b111:  alu_op = AOP_AND;
                    3'b110:  alu_op = AOP_OR;
                    3'b000:  alu_op = (funct7 == F7_ALT) ? AOP_SUB : AOP_ADD;
                    default: alu_op = AOP_ADD;
                endcase
            end
            default:    alu_op = AOP_ADD;
        endcase
    end

endmodule

// File: rtl/sc_immgen.sv
// Module: immediate extractor. Picks the 12-bit field laid out by the
// instruction format and sign-extends it; branch offsets leave here in
// half-word units (the caller shifts them).
module sc_immgen
    import sc_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [31:0]     instr,
    output logic [XLEN-1:0] imm
);

    logic [11:0] field;

    // Gather the immediate bits for the format implied by the opcode
    always_comb begin
        case (instr[6:0])
            OPC_LOAD:   field = instr[31:20];
            OPC_STORE:  field = {instr[31:25], instr[11:7]};
            OPC_BRANCH: field = {instr[31], instr[7], instr[30:25], instr[11:8]};
            default:    field = '0;
        endcase
    end

    assign imm = {{(XLEN-12){field[11]}}, field};

endmodule

// File: rtl/sc_alu.sv
// Module: XLEN-wide ALU with a zero flag. Only the four operation codes
// of the package are meaningful; any other code adds.
module sc_alu
    import sc_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  alu_op_e         op,
    output logic [XLEN-1:0] y,
    output logic            zero
);

    // Operation select
    always_comb begin
        case (op)
            AOP_AND: y = a & b;
            AOP_OR:  y = a | b;
            AOP_SUB: y = a - b;
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/sc_regfile.sv
// Module: register file with two asynchronous read ports and one write
// port on the rising edge. Entry 0 is hardwired to zero and never stored.
module sc_regfile #(
    parameter int XLEN = 64,
    parameter int NREG = 32
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [$clog2(NREG)-1:0] waddr,
    input  logic [XLEN-1:0]         wdata,
    input  logic [$clog2(NREG)-1:0] raddr_a,
    input  logic [$clog2(NREG)-1:0] raddr_b,
    output logic [XLEN-1:0]         rdata_a,
    output logic [XLEN-1:0]         rdata_b
);

    logic [XLEN-1:0] regs_q [NREG];

    // Write port, entry 0 excluded
    always_ff @(posedge clk) begin
        if (we && waddr != '0) regs_q[waddr] <= wdata;
    end

    assign rdata_a = (raddr_a == '0) ? '0 : regs_q[raddr_a];
    assign rdata_b = (raddr_b == '0) ? '0 : regs_q[raddr_b];

endmodule

// File: rtl/sc_core64.sv
// Module: single-cycle core top. Holds the program counter, both memory
// arrays and the datapath multiplexers. Assumes the arrays are loaded
// through the programming port while rst_n is low; during reset no
// architectural write happens. Data accesses are 64-bit and aligned.
module sc_core64
    import sc_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int NREG   = 32,
    parameter int MEM_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_we,
    input  logic              prog_dsel,
    input  logic [MEM_AW-1:0] prog_addr,
    input  logic [XLEN-1:0]   prog_data,
    output logic [XLEN-1:0]   pc_o,
    output logic              rf_we_o,
    output logic [4:0]        rf_waddr_o,
    output logic [XLEN-1:0]   rf_wdata_o,
    output logic              dm_we_o,
    output logic [XLEN-1:0]   dm_addr_o,
    output logic [XLEN-1:0]   dm_wdata_o,
    output logic              branch_taken_o
);

    localparam int MEM_WORDS = 1 << MEM_AW;
    localparam int DW_SHIFT  = $clog2(XLEN / 8);
    localparam int RAW       = $clog2(NREG);

    logic [XLEN-1:0] pc_q;
    logic [31:0]     imem [MEM_WORDS];
    logic [XLEN-1:0] dmem [MEM_WORDS];

    logic [31:0]     instr;
    ctrl_t           ctrl;
    alu_op_e         alu_op;
    logic [XLEN-1:0] imm;
    logic [XLEN-1:0] rs1_val;
    logic [XLEN-1:0] rs2_val;
    logic [XLEN-1:0] alu_b;
    logic [XLEN-1:0] alu_y;
    logic            alu_zero;
    logic [XLEN-1:0] mem_rdata;
    logic [XLEN-1:0] wb_data;
    logic [XLEN-1:0] pc_seq;
    logic [XLEN-1:0] pc_tgt;
    logic            take_br;
    logic            rf_we;
    logic            dm_we;

    assign instr = imem[pc_q[MEM_AW+1:2]];

    sc_decode u_dec (
        .opcode (instr[6:0]),
        .funct3 (instr[14:12]),
        .funct7 (instr[31:25]),
        .ctrl   (ctrl),
        .alu_op (alu_op)
    );

    sc_immgen #(.XLEN(XLEN)) u_imm (
        .instr (instr),
        .imm   (imm)
    );

    sc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk     (clk),
        .we      (rf_we),
        .waddr   (instr[7+RAW-1:7]),
        .wdata   (wb_data),
        .raddr_a (instr[15+RAW-1:15]),
        .raddr_b (instr[20+RAW-1:20]),
        .rdata_a (rs1_val),
        .rdata_b (rs2_val)
    );

    assign alu_b = ctrl.b_from_imm ? imm : rs2_val;

    sc_alu #(.XLEN(XLEN)) u_alu (
        .a    (rs1_val),
        .b    (alu_b),
        .op   (alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign mem_rdata = ctrl.mem_rd ? dmem[alu_y[MEM_AW+DW_SHIFT-1:DW_SHIFT]] : '0;
    assign wb_data   = ctrl.wb_from_mem ? mem_rdata : alu_y;

    assign pc_seq  = pc_q + XLEN'(4);
    assign pc_tgt  = pc_q + (imm << 1);
    assign take_br = ctrl.is_branch & alu_zero & rst_n;
    assign rf_we   = ctrl.reg_wr & rst_n;
    assign dm_we   = ctrl.mem_wr & rst_n;

    // Program counter update, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= take_br ? pc_tgt : pc_seq;
    end

    // Instruction array: filled only through the programming port
    always_ff @(posedge clk) begin
        if (prog_we && !prog_dsel) imem[prog_addr] <= prog_data[31:0];
    end

    // Data array: programming port, else stores from the core
    always_ff @(posedge clk) begin
        if (prog_we && prog_dsel)
            dmem[prog_addr] <= prog_data;
        else if (dm_we)
            dmem[alu_y[MEM_AW+DW_SHIFT-1:DW_SHIFT]] <= rs2_val;
    end

    assign pc_o           = pc_q;
    assign rf_we_o        = rf_we;
    assign rf_waddr_o     = instr[11:7];
    assign rf_wdata_o     = wb_data;
    assign dm_we_o        = dm_we;
    assign dm_addr_o      = alu_y;
    assign dm_wdata_o     = rs2_val;
    assign branch_taken_o = take_br;

endmodule

// File: rtl/sc_core64_chk.sv
// Module: property checker for sc_core64, attached by bind. Observes the
// top-level outputs plus the fetched opcode and the first read port.
module sc_core64_chk
    import sc_pkg::*;
#(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] pc_o,
    input logic            rf_we_o,
    input logic            dm_we_o,
    input logic            branch_taken_o,
    input logic [6:0]      opcode,
    input logic [4:0]      rs1_addr,
    input logic [XLEN-1:0] rs1_val
);

    logic known_op;
    assign known_op = (opcode == OPC_REG) || (opcode == OPC_LOAD) ||
                      (opcode == OPC_STORE) || (opcode == OPC_BRANCH);

    a_r1_pc_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pc_o == '0));

    a_r2_sequential_step: assert property (@(posedge clk) disable iff (!rst_n)
        !branch_taken_o |=> (pc_o == $past(pc_o) + XLEN'(4)));

    a_r5_store_no_regwrite: assert property (@(posedge clk) disable iff (!rst_n)
        dm_we_o |-> !rf_we_o);

    a_r6_taken_only_on_branch: assert property (@(posedge clk) disable iff (!rst_n)
        branch_taken_o |-> (opcode == OPC_BRANCH));

    a_r7_zero_reg_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rs1_addr == 5'd0) |-> (rs1_val == '0));

    a_r8_unknown_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !known_op |-> (!rf_we_o && !dm_we_o && !branch_taken_o));

endmodule

bind sc_core64 sc_core64_chk #(.XLEN(XLEN)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .pc_o           (pc_o),
    .rf_we_o        (rf_we_o),
    .dm_we_o        (dm_we_o),
    .branch_taken_o (branch_taken_o),
    .opcode         (instr[6:0]),
    .rs1_addr       (instr[19:15]),
    .rs1_val        (rs1_val)
);

// File: tb/test_sc_core64.sv
`timescale 1ns/1ps
module test_sc_core64;

    localparam int XLEN   = 64;
    localparam int MEM_AW = 6;
    localparam int NPROG  = 18;
    localparam int NCYC   = 30;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              prog_we = 1'b0;
    logic              prog_dsel = 1'b0;
    logic [MEM_AW-1:0] prog_addr = '0;
    logic [XLEN-1:0]   prog_data = '0;
    logic [XLEN-1:0]   pc_o;
    logic              rf_we_o;
    logic [4:0]        rf_waddr_o;
    logic [XLEN-1:0]   rf_wdata_o;
    logic              dm_we_o;
    logic [XLEN-1:0]   dm_addr_o;
    logic [XLEN-1:0]   dm_wdata_o;
    logic              branch_taken_o;

    always #2.5 clk = ~clk;

    sc_core64 #(.XLEN(XLEN), .NREG(32), .MEM_AW(MEM_AW)) i_sc_core64 (
        .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_dsel(prog_dsel),
        .prog_addr(prog_addr), .prog_data(prog_data), .pc_o(pc_o),
        .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
        .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o),
        .branch_taken_o(branch_taken_o)
    );

    typedef struct {
        logic [63:0] pc;
        logic        rf_we;
        logic [4:0]  rd;
        logic [63:0] wdata;
        logic        dm_we;
        logic [63:0] addr;
        logic [63:0] sdata;
        logic        taken;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    int          n_chk = 0;
    int          n_bad = 0;
    bit          finished = 1'b0;
    logic [31:0] prog [NPROG];
    logic [63:0] m_mem [1<<MEM_AW];
    logic [63:0] m_reg [32];
    logic [63:0] m_pc;

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [4:0] rs2,
            input logic [4:0] rs1, input logic [2:0] f3, input logic [4:0] rd);
        return {f7, rs2, rs1, f3, rd, 7'b0110011};
    endfunction
    function automatic logic [31:0] enc_ld(input logic [11:0] im, input logic [4:0] rs1,
            input logic [4:0] rd);
        return {im, rs1, 3'b011, rd, 7'b0000011};
    endfunction
    function automatic logic [31:0] enc_sd(input logic [11:0] im, input logic [4:0] rs2,
            input logic [4:0] rs1);
        return {im[11:5], rs2, rs1, 3'b011, im[4:0], 7'b0100011};
    endfunction
    function automatic logic [31:0] enc_beq(input logic [12:0] im, input logic [4:0] rs2,
            input logic [4:0] rs1);
        return {im[12], im[10:5], rs2, rs1, 3'b000, im[4:1], im[11], 7'b1100011};
    endfunction

    function automatic logic [63:0] rd_reg(input logic [4:0] r);
        return (r == 5'd0) ? 64'd0 : m_reg[r];
    endfunction

    // Driver: reference model runs ahead and queues one item per cycle
    task automatic plan_run();
        m_pc = '0;
        for (int c = 0; c < NCYC; c++) begin
            exp_t        e;
            logic [31:0] ins;
            logic [63:0] a, b, res, imm;
            ins = prog[m_pc[6:2]];
            a = rd_reg(ins[19:15]);
            b = rd_reg(ins[24:20]);
            e = '{pc: m_pc, rf_we: 1'b0, rd: ins[11:7], wdata: '0, dm_we: 1'b0,
                  addr: '0, sdata: '0, taken: 1'b0, tag: "R8"};
            case (ins[6:0])
                7'b0110011: begin
                    case (ins[14:12])
                        3'b111:  res = a & b;
                        3'b110:  res = a | b;
                        default: res = (ins[31:25] == 7'b0100000) ? a - b : a + b;
                    endcase
                    e.rf_we = 1'b1; e.wdata = res;
                    e.tag = (ins[11:7] == 0 || ins[19:15] == 0) ? "R7" : "R3";
                    if (ins[11:7] != 0) m_reg[ins[11:7]] = res;
                    m_pc = m_pc + 4;
                end
                7'b0000011: begin
                    imm = {{52{ins[31]}}, ins[31:20]};
                    res = m_mem[(a + imm) >> 3];
                    e.rf_we = 1'b1; e.wdata = res; e.tag = "R4,R9";
                    if (ins[11:7] != 0) m_reg[ins[11:7]] = res;
                    m_pc = m_pc + 4;
                end
                7'b0100011: begin
                    imm = {{52{ins[31]}}, ins[31:25], ins[11:7]};
                    e.dm_we = 1'b1; e.addr = a + imm; e.sdata = b; e.tag = "R5";
                    m_mem[(a + imm) >> 3] = b;
                    m_pc = m_pc + 4;
                end
                7'b1100011: begin
                    imm = {{51{ins[31]}}, ins[31], ins[7], ins[30:25], ins[11:8], 1'b0};
                    e.taken = (a == b); e.tag = "R6";
                    m_pc = e.taken ? m_pc + imm : m_pc + 4;
                end
                default: m_pc = m_pc + 4;
            endcase
            sb_q.push_back(e);
        end
    endtask

    task automatic put_word(input logic dsel, input int idx, input logic [63:0] d);
        @(negedge clk);
        prog_we = 1'b1; prog_dsel = dsel; prog_addr = MEM_AW'(idx); prog_data = d;
    endtask

    // Monitor: compares one queued item per cycle against the ports
    task automatic compare_item(input exp_t e);
        string pt;
        pt = (e.taken || e.tag == "R6") ? "R6" : "R2";
        check(pt, "pc", pc_o, e.pc);
        check(e.tag, "rf_we", {63'd0, rf_we_o}, {63'd0, e.rf_we});
        check(e.tag, "dm_we", {63'd0, dm_we_o}, {63'd0, e.dm_we});
        check(e.tag, "taken", {63'd0, branch_taken_o}, {63'd0, e.taken});
        if (e.rf_we) begin
            check(e.tag, "rd", {59'd0, rf_waddr_o}, {59'd0, e.rd});
            check(e.tag, "wdata", rf_wdata_o, e.wdata);
        end
        if (e.dm_we) begin
            check(e.tag, "addr", dm_addr_o, e.addr);
            check(e.tag, "sdata", dm_wdata_o, e.sdata);
        end
    endtask

    initial begin
        prog[0]  = enc_ld(12'd0, 5'd0, 5'd1);
        prog[1]  = enc_ld(12'd8, 5'd0, 5'd2);
        prog[2]  = enc_r(7'b0000000, 5'd2, 5'd1, 3'b000, 5'd3);
        prog[3]  = enc_r(7'b0100000, 5'd2, 5'd1, 3'b000, 5'd4);
        prog[4]  = enc_r(7'b0000000, 5'd2, 5'd1, 3'b111, 5'd5);
        prog[5]  = enc_r(7'b0000000, 5'd2, 5'd1, 3'b110, 5'd6);
        prog[6]  = enc_sd(12'd24, 5'd3, 5'd0);
        prog[7]  = enc_ld(12'd24, 5'd0, 5'd7);              // R9 store then load
        prog[8]  = enc_r(7'b0000000, 5'd1, 5'd1, 3'b000, 5'd0); // R7 write to x0
        prog[9]  = enc_r(7'b0000000, 5'd0, 5'd0, 3'b000, 5'd8); // R7 read of x0
        prog[10] = enc_beq(13'd8, 5'd2, 5'd1);              // not taken
        prog[11] = enc_ld(12'd16, 5'd0, 5'd9);
        prog[12] = enc_ld(-12'sd8, 5'd9, 5'd10);            // negative offset
        prog[13] = enc_beq(13'd12, 5'd10, 5'd9);            // taken forward
        prog[14] = enc_sd(12'd0, 5'd1, 5'd0);
        prog[15] = enc_sd(12'd0, 5'd1, 5'd0);
        prog[16] = 32'hFFFF_FFFF;                            // R8 unknown opcode
        prog[17] = enc_beq(-13'sd16, 5'd0, 5'd0);           // taken backward
        for (int i = 0; i < (1<<MEM_AW); i++) m_mem[i] = 64'(i) * 64'h0101_0101;
        m_mem[0] = 64'h1234_5678_9ABC_DEF0;
        m_mem[1] = 64'hFF00_FF00_0F0F_F0F0;
        m_mem[2] = 64'd24;
        for (int i = 0; i < 32; i++) m_reg[i] = '0;

        for (int i = 0; i < NPROG; i++) put_word(1'b0, i, {32'd0, prog[i]});
        for (int i = 0; i < (1<<MEM_AW); i++) put_word(1'b1, i, m_mem[i]);
        @(negedge clk);
        prog_we = 1'b0;
        repeat (2) @(negedge clk);
        // R1: held in reset, no writes and PC at zero
        check("R1", "pc", pc_o, 64'd0);
        check("R1", "rf_we", {63'd0, rf_we_o}, 64'd0);
        check("R1", "dm_we", {63'd0, dm_we_o}, 64'd0);

        plan_run();
        rst_n = 1'b1;
        #1;
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            compare_item(e);
            @(negedge clk);
            #1;
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule